// File: doc/BRIEF.md
# Framed Serial Command Word Receiver

This block takes 16-bit command words from a three-wire link: an active-low select, a serial clock and a serial data line. All three pins are oversampled in the system clock domain, so the serial clock must run at no more than one quarter of the system clock. A frame opens when select falls. Data bits are captured on each rising serial clock edge, most significant bit first. The frame is judged when select returns high.

A frame is accepted only if it held exactly sixteen rising serial clock edges and its two trailing sub-bits are zero. An accepted frame produces a one-cycle strobe, together with a 4-bit control field and a 10-bit data field for the register logic downstream. Frames of any other length are dropped without a trace. A correct-length frame with nonzero sub-bits is also dropped, and it raises an error flag that stays set until reset.

The controller has three states. IDLE waits for select to fall, then moves to RECV and clears the bit counter. RECV counts and shifts bits. On a seventeenth rising edge it moves to DROP, and on a select rise it returns to IDLE, deciding at that moment whether to strobe. DROP waits for select to rise, then returns to IDLE without a strobe.

Top module: `cmd_word_rx`

## Requirements
- R1: While reset is asserted and right after it, `cmd_valid_o` and `sub_err_o` are 0, and both `cmd_ctrl_o` and `cmd_data_o` are 0.
- R2: Bit 1 shifted in becomes `cmd_ctrl_o[3]` and bit 4 becomes `cmd_ctrl_o[0]`. Bits 5 to 14 become `cmd_data_o[9]` down to `cmd_data_o[0]`. Bits 15 and 16 are the sub-bits, and both must be 0.
- R3: For an accepted frame, `cmd_valid_o` is high for exactly one system clock cycle. That cycle follows the third rising `clk` edge that samples `sel_n_i` high after the frame.
- R4: A frame with fewer than 16 rising serial clock edges produces no strobe and leaves the fields unchanged.
- R5: A frame with more than 16 rising serial clock edges produces no strobe and leaves the fields unchanged.
- R6: A 16-bit frame with nonzero sub-bits produces no strobe and sets `sub_err_o`. The flag stays 1 until reset, including through later valid frames.
- R7: Serial clock edges while `sel_n_i` is high have no effect on the next frame.
- R8: The bit counter clears on every falling edge of select. Two frames separated by a select-high pulse of three system clocks are each decoded on their own.
- R9: `cmd_ctrl_o` and `cmd_data_o` change only in a cycle where `cmd_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_clk_i | input | 1 | Serial clock; data is captured on its rising edge |
| sel_n_i | input | 1 | Active-low frame select |
| serial_dat_i | input | 1 | Serial data, most significant bit first |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted frame |
| cmd_ctrl_o | output | 4 | Control field of the last accepted frame |
| cmd_data_o | output | 10 | Data field of the last accepted frame |
| sub_err_o | output | 1 | Sticky flag for a frame with nonzero sub-bits |

## Verification
The hardest situation to reach from the ports is the edge of the length check. A seventeenth rising serial clock edge has to send the controller into DROP. A select pulse that is only three system clocks wide has to be seen as a full frame boundary, so that the next frame's counter restarts. The stimulus reaches both. It sends frames of 15, 16 and 17 bits with identical payloads. It also runs back-to-back frames with a minimal select-high gap. Each clock, a delayed behavioural model of the pins is compared with the outputs, so a strobe that fires one cycle early or late is caught as well as a missing one.

// File: rtl/cmd_word_rx_pkg.sv
package cmd_word_rx_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;

endpackage

// File: rtl/cmdrx_sync.sv
// Multi-stage synchronizer for a small group of asynchronous pins.
module cmdrx_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cmdrx_edge.sv
// Rising and falling edge detection on synchronized levels.
module cmdrx_edge #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= RST_VAL;
        else        dly_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~dly_q;
    assign fall_o = ~lvl_i & dly_q;

endmodule

// File: rtl/cmdrx_shifter.sv
// Frame shift register with a saturating bit counter.
module cmdrx_shifter #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (clear_i) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (shift_i) begin
            if (cnt_o < CNT_FULL) word_o <= {word_o[FRAME_W-2:0], bit_i};
            if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx
    import cmd_word_rx_pkg::*;
#(
    parameter int CTRL_W      = 4,
    parameter int DATA_W      = 10,
    parameter int SUB_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_clk_i,
    input  logic              sel_n_i,
    input  logic              serial_dat_i,
    output logic              cmd_valid_o,
    output logic [CTRL_W-1:0] cmd_ctrl_o,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic              sub_err_o
);

    localparam int FRAME_W = CTRL_W + DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    // Pin group order: {select, serial clock, serial data}
    localparam logic [2:0] PIN_IDLE = 3'b100;

    logic [2:0]         pins_s;
    logic [1:0]         rise_v, fall_v;
    logic               sel_rise, sel_fall, sck_rise;
    logic [FRAME_W-1:0] shift_word;
    logic [CNT_W-1:0]   bit_cnt;
    logic               clr_cnt, do_shift, frame_end_ok;
    logic [SUB_W-1:0]   sub_bits;
    rx_state_e          state_q, state_d;

    cmdrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, serial_clk_i, serial_dat_i}),
        .q_o   (pins_s)
    );

    cmdrx_edge #(.W(2), .RST_VAL(PIN_IDLE[2:1])) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_s[2:1]),
        .rise_o (rise_v),
        .fall_o (fall_v)
    );

    assign sel_rise = rise_v[1];
    assign sel_fall = fall_v[1];
    assign sck_rise = rise_v[0];

    cmdrx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr_cnt),
        .shift_i (do_shift),
        .bit_i   (pins_s[0]),
        .word_o  (shift_word),
        .cnt_o   (bit_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (sel_fall) state_d = RX_RECV;
            RX_RECV: begin
                if (sel_rise)
                    state_d = RX_IDLE;
                else if (sck_rise && bit_cnt == CNT_FULL)
                    state_d = RX_DROP;
            end
            RX_DROP: if (sel_rise) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    assign clr_cnt      = (state_q == RX_IDLE) && sel_fall;
    assign do_shift     = (state_q == RX_RECV) && sck_rise && !sel_rise;
    assign frame_end_ok = (state_q == RX_RECV) && sel_rise && (bit_cnt == CNT_FULL);
    assign sub_bits     = shift_word[SUB_W-1:0];

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_ctrl_o  <= '0;
            cmd_data_o  <= '0;
            sub_err_o   <= 1'b0;
        end else begin
            cmd_valid_o <= frame_end_ok && (sub_bits == '0);
            if (frame_end_ok && (sub_bits == '0)) begin
                cmd_ctrl_o <= shift_word[FRAME_W-1 -: CTRL_W];
                cmd_data_o <= shift_word[SUB_W +: DATA_W];
            end
            if (frame_end_ok && (sub_bits != '0)) sub_err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/cmd_word_rx_chk.sv
module cmd_word_rx_chk
    import cmd_word_rx_pkg::*;
#(
    parameter int CTRL_W  = 4,
    parameter int DATA_W  = 10,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid_o,
    input logic [CTRL_W-1:0] cmd_ctrl_o,
    input logic [DATA_W-1:0] cmd_data_o,
    input logic              sub_err_o,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  cnt
);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_exact_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(cnt) == CNT_W'(FRAME_W));

    assert_drop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == RX_DROP |=> !cmd_valid_o);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_err_o |=> sub_err_o);

    assert_idle_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state) == RX_IDLE |-> !cmd_valid_o);

    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> ($stable(cmd_ctrl_o) && $stable(cmd_data_o)));

endmodule

bind cmd_word_rx cmd_word_rx_chk #(
    .CTRL_W  (CTRL_W),
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ctrl_o  (cmd_ctrl_o),
    .cmd_data_o  (cmd_data_o),
    .sub_err_o   (sub_err_o),
    .state       (state_q),
    .cnt         (bit_cnt)
);

// File: tb/cmd_word_rx_bench.sv
module cmd_word_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       csn = 1'b1;
    logic       sdi = 1'b0;
    logic       valid;
    logic [3:0] ctrl;
    logic [9:0] data;
    logic       err;

    int    checks = 0;
    int    errors = 0;
    int    strobes = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    cmd_word_rx u_cmd_word_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .serial_clk_i (sclk),
        .sel_n_i      (csn),
        .serial_dat_i (sdi),
        .cmd_valid_o  (valid),
        .cmd_ctrl_o   (ctrl),
        .cmd_data_o   (data),
        .sub_err_o    (err)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: pin history, judged two samples late
    logic [2:0]  hist_q[$];
    bit          m_valid, m_err, m_act;
    logic [3:0]  m_ctrl;
    logic [9:0]  m_data;
    logic [15:0] m_word;
    int          m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_q  = '{3'b100, 3'b100, 3'b100};
            m_valid = 0; m_err = 0; m_act = 0;
            m_ctrl  = '0; m_data = '0; m_word = '0; m_cnt = 0;
        end else begin
            logic [2:0] cur, prv;
            hist_q.push_back({csn, sclk, sdi});
            if (hist_q.size() > 4) void'(hist_q.pop_front());
            cur = hist_q[1];
            prv = hist_q[0];
            m_valid = 0;
            if (prv[2] && !cur[2]) begin
                m_act = 1; m_cnt = 0; m_word = '0;
            end else if (!prv[2] && cur[2]) begin
                if (m_act && m_cnt == 16) begin
                    if (m_word[1:0] == 2'b00) begin
                        m_valid = 1;
                        m_ctrl  = m_word[15:12];
                        m_data  = m_word[11:2];
                    end else begin
                        m_err = 1;
                    end
                end
                m_act = 0;
            end else if (m_act && !cur[2] && cur[1] && !prv[1]) begin
                if (m_cnt < 16) m_word = {m_word[14:0], cur[0]};
                if (m_cnt < 17) m_cnt++;
            end
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "valid", 32'(valid), 32'(m_valid));
            chk(tag, "sub_err", 32'(err), 32'(m_err));
            chk(tag, "ctrl", 32'(ctrl), 32'(m_ctrl));
            chk(tag, "data", 32'(data), 32'(m_data));
            if (valid) strobes++;
        end
    end

    task automatic send(int nbits, logic [31:0] w, int gap);
        @(negedge clk) csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = w[i]; sclk = 1'b0;
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        csn = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic [31:0] fw(logic [3:0] c, logic [9:0] d, logic [1:0] s);
        return {16'h0, c, d, s};
    endfunction

    task automatic expect_frame(string req, int n_strobe, logic [3:0] c, logic [9:0] d, logic e);
        chk(req, "strobe count", 32'(strobes), 32'(n_strobe));
        chk(req, "ctrl field", 32'(ctrl), 32'(c));
        chk(req, "data field", 32'(data), 32'(d));
        chk(req, "sub_err flag", 32'(err), 32'(e));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(valid), 0);
        chk("R1", "err in reset", 32'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_frame("R1", 0, 4'h0, 10'h000, 1'b0);

        // R2, R3: field layout and strobe
        tag = "R2";
        send(16, fw(4'h1, 10'h2A5, 2'b00), 8);
        expect_frame("R2", 1, 4'h1, 10'h2A5, 1'b0);
        tag = "R3";
        send(16, fw(4'hF, 10'h3FF, 2'b00), 8);
        expect_frame("R3", 2, 4'hF, 10'h3FF, 1'b0);
        send(16, fw(4'h8, 10'h001, 2'b00), 8);
        expect_frame("R2", 3, 4'h8, 10'h001, 1'b0);

        // R7: serial clock activity with select high
        tag = "R7";
        sdi = 1'b1;
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        expect_frame("R7", 3, 4'h8, 10'h001, 1'b0);
        send(16, fw(4'h4, 10'h155, 2'b00), 8);
        expect_frame("R7", 4, 4'h4, 10'h155, 1'b0);

        // R4: short frame
        tag = "R4";
        send(15, fw(4'hA, 10'h0F0, 2'b00) >> 1, 8);
        expect_frame("R4", 4, 4'h4, 10'h155, 1'b0);

        // R5: long frame
        tag = "R5";
        send(17, fw(4'hA, 10'h0F0, 2'b00) << 1, 8);
        expect_frame("R5", 4, 4'h4, 10'h155, 1'b0);

        // R8: back-to-back frames with a short select gap
        tag = "R8";
        send(16, fw(4'h2, 10'h123, 2'b00), 2);
        send(16, fw(4'hD, 10'h3C3, 2'b00), 8);
        expect_frame("R8", 6, 4'hD, 10'h3C3, 1'b0);
        send(15, fw(4'h6, 10'h111, 2'b00) >> 1, 2);
        send(16, fw(4'h9, 10'h222, 2'b00), 8);
        expect_frame("R8", 7, 4'h9, 10'h222, 1'b0);

        // R6: nonzero sub-bits, sticky flag
        tag = "R6";
        send(16, fw(4'h3, 10'h0AA, 2'b01), 8);
        expect_frame("R6", 7, 4'h9, 10'h222, 1'b1);
        send(16, fw(4'h5, 10'h2BC, 2'b10), 8);
        expect_frame("R6", 7, 4'h9, 10'h222, 1'b1);
        tag = "R9";
        send(16, fw(4'h7, 10'h0C3, 2'b00), 8);
        expect_frame("R9", 8, 4'h7, 10'h0C3, 1'b1);

        // R1, R6: reset clears the flag and fields
        tag = "R1";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_frame("R6", 8, 4'h0, 10'h000, 1'b0);
        send(16, fw(4'hE, 10'h3A1, 2'b00), 8);
        expect_frame("R2", 9, 4'hE, 10'h3A1, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R3 watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule